// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. While its run input is high it repeats a fixed cycle. First it holds the track-and-hold switch closed for a parameterised number of clocks. It then resolves the code by binary search, from the top bit down, with one comparator decision per clock. During the search it drives the trial word to the DAC. The comparator, the capacitive DAC and the track-and-hold switch sit outside this block. The block only sees a single comparator bit and drives digital control.

A conversion of `N_BITS` bits with `SAMPLE_CLKS` sampling clocks occupies exactly `N_BITS + SAMPLE_CLKS` clocks. The finished code is handed off in the first clock of the following sampling phase. In that same clock the working word is returned to zero. The hand-off is one-way, with no back-pressure: the `done_o` pulse lasts one clock and acts as a valid strobe. `result_o` keeps its value until the next strobe, so a consumer has a full conversion period to take it. If the run input is lowered during a conversion, that conversion still completes and delivers its code, and the controller then rests idle.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted, `sample_o`, `done_o`, `dac_code_o` and `result_o` are all zero.
- R2: Each conversion begins with `sample_o` high for exactly `SAMPLE_CLKS` consecutive clocks.
- R3: In the first clock after sampling ends, `dac_code_o` has only its most significant bit set (1000000000 for 10 bits).
- R4: Trials proceed one bit per clock, from the most significant bit down to bit 0. In the trial for bit k, `dac_code_o` holds the decisions already made for the bits above k, a 1 at bit k, and zeros below k.
- R5: The comparator bit `cmp_i` sampled at the end of a trial decides that trial's bit. A value of 1 (input at least the DAC level) keeps the bit, and 0 clears it.
- R6: `done_o` is high for exactly one clock, the first clock of the next sampling phase. In that clock `result_o` shows the decided word, and `result_o` does not change in clocks where `done_o` is low.
- R7: While `start_i` stays high, conversions run back to back and successive `done_o` pulses are `N_BITS + SAMPLE_CLKS` clocks apart.
- R8: If `start_i` is low when the last trial ends, the result is still delivered. After that the block stays idle, with `sample_o`, `done_o` and `dac_code_o` at zero, until `start_i` rises again.
- R9: `dac_code_o` is zero throughout every sampling clock.
- R10: With an ideal comparator (`cmp_i` = input code >= `dac_code_o`), `result_o` equals the input code held during the trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run enable; conversions repeat while high |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at least the DAC level |
| dac_code_o | output | N_BITS | Trial word for the DAC |
| sample_o | output | 1 | Track-and-hold control, high while sampling |
| result_o | output | N_BITS | Last finished conversion code |
| done_o | output | 1 | One-clock strobe marking a new `result_o` |

## Verification
The comparator is modelled as an ideal quantiser on an input code that is chosen in each sampling phase. A few codes are directed: zero, all ones, midscale, one below midscale and one. The rest are random. The all-zeros and all-ones codes show whether every trial bit can be both cleared and kept. The two codes around midscale tell apart the top-bit decision from the lower bits. The trial word is compared against the expected partial code in every trial clock, so a wrong bit order or a decision applied to the wrong bit shows up before the final result. The run input is lowered in the middle of a conversion and raised again after an idle stretch, which exercises delivery on stop and restart from idle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int N_BITS      = 10,
  parameter int SAMPLE_CLKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic [$clog2(N_BITS)-1:0] bit_idx_o,
  output logic                      sample_o,
  output logic                      load_msb_o,
  output logic                      trial_o,
  output logic                      last_o
);
  localparam int IDX_W = $clog2(N_BITS);
  localparam int CNT_W = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SAMPLE_CLKS - 1);

  sar_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= '0;
          end
        end
        PH_SAMPLE: begin
          if (cnt_q == CNT_END) begin
            phase_q <= PH_TRIAL;
            idx_q   <= TOP_IDX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_TRIAL: begin
          if (idx_q == '0) begin
            phase_q <= start_i ? PH_SAMPLE : PH_IDLE;
            cnt_q   <= '0;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bit_idx_o  = idx_q;
  assign sample_o   = (phase_q == PH_SAMPLE);
  assign load_msb_o = (phase_q == PH_SAMPLE) && (cnt_q == CNT_END);
  assign trial_o    = (phase_q == PH_TRIAL);
  assign last_o     = (phase_q == PH_TRIAL) && (idx_q == '0);

  // R4: one bit per clock, descending
  assert_trial_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_o && !last_o) |=> (trial_o && bit_idx_o == $past(bit_idx_o) - 1'b1));

  // R2/R3: sampling hands over to the top-bit trial
  assert_sample_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_msb_o |=> (trial_o && bit_idx_o == TOP_IDX));

  // R8: stop request honoured only at the end of a conversion
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> (phase_q == PH_IDLE));

  // R7: a running controller restarts sampling immediately
  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && start_i) |=> sample_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N_BITS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_msb_i,
  input  logic                      trial_i,
  input  logic                      last_i,
  input  logic [$clog2(N_BITS)-1:0] bit_idx_i,
  input  logic                      cmp_i,
  output logic [N_BITS-1:0]         dac_code_o,
  output logic [N_BITS-1:0]         decided_o
);
  localparam logic [N_BITS-1:0] ONE = N_BITS'(1);
  localparam logic [N_BITS-1:0] MSB = ONE << (N_BITS - 1);

  logic [N_BITS-1:0] work_q;
  logic [N_BITS-1:0] cur_mask;
  logic [N_BITS-1:0] next_word;

  always_comb begin
    cur_mask  = ONE << bit_idx_i;
    decided_o = (work_q & ~cur_mask) | (cmp_i ? cur_mask : '0);
    next_word = decided_o | (cur_mask >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (load_msb_i) begin
      work_q <= MSB;
    end else if (trial_i) begin
      work_q <= last_i ? '0 : next_word;
    end
  end

  assign dac_code_o = work_q;

  // R3: first trial word is the top bit alone
  assert_first_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_msb_i |=> (dac_code_o == MSB));

  // R5: the tried bit follows the comparator
  assert_keep_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_i && !last_i) |=> (((dac_code_o & $past(cur_mask)) != '0) == $past(cmp_i)));

  // R9: working word cleared when the next sampling phase begins
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> (dac_code_o == '0));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int N_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_i,
  input  logic [N_BITS-1:0] decided_i,
  output logic [N_BITS-1:0] result_o,
  output logic              done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) result_o <= decided_i;
    end
  end

  // R6: single-clock strobe
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: result held between strobes
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N_BITS      = 10,
  parameter int SAMPLE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] dac_code_o,
  output logic              sample_o,
  output logic [N_BITS-1:0] result_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(N_BITS);

  logic [IDX_W-1:0]  bit_idx;
  logic              load_msb;
  logic              trial;
  logic              last;
  logic [N_BITS-1:0] decided;

  sar_sequencer #(.N_BITS(N_BITS), .SAMPLE_CLKS(SAMPLE_CLKS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_idx_o  (bit_idx),
    .sample_o   (sample_o),
    .load_msb_o (load_msb),
    .trial_o    (trial),
    .last_o     (last)
  );

  sar_trial_reg #(.N_BITS(N_BITS)) i_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_msb_i (load_msb),
    .trial_i    (trial),
    .last_i     (last),
    .bit_idx_i  (bit_idx),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .decided_o  (decided)
  );

  sar_result #(.N_BITS(N_BITS)) i_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_i    (last),
    .decided_i (decided),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  // R9: DAC word idle during sampling
  assert_sample_dac_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_code_o == '0));

  // R6: strobe coincides with the start of a sampling phase or idle
  assert_done_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !trial);
endmodule

// File: tb/test_sar_ctrl.sv
module test_sar_ctrl;
  localparam int N = 10;
  localparam int M = 2;
  localparam int PERIOD = N + M;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [N-1:0] dac_code, result;
  logic sample, done;
  int   vin;
  logic cmp;

  assign cmp = (vin >= int'(dac_code));

  sar_ctrl #(.N_BITS(N), .SAMPLE_CLKS(M)) i_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .dac_code_o(dac_code), .sample_o(sample), .result_o(result), .done_o(done)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int k = -1, run_len = 0, since_done = 0, conv_idx = 0, dones_after_stop = 0;
  bit prev_sample = 0, prev_done = 0, have_done = 0, finished = 0;
  int last_result = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick_code(input int idx);
    case (idx)
      0: return 0;
      1: return (1 << N) - 1;
      2: return 1 << (N - 1);
      3: return (1 << (N - 1)) - 1;
      4: return 1;
      default: return int'($urandom) & ((1 << N) - 1);
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    since_done++;
    // R6/R10: delivered code
    if (done) begin
      chk(int'(result) == vin, "R10", int'(result), vin);
      chk(!prev_done, "R6", int'(prev_done), 0);
      if (have_done) chk(since_done == PERIOD, "R7", since_done, PERIOD);
      have_done = 1; since_done = 0; last_result = int'(result);
      if (!start) dones_after_stop++;
    end else begin
      chk(int'(result) == last_result, "R6", int'(result), last_result);
    end
    // R2/R3/R9: sampling and first trial
    if (sample) begin
      chk(dac_code == '0, "R9", int'(dac_code), 0);
      run_len++;
      k = -1;
    end else if (prev_sample) begin
      chk(run_len == M, "R2", run_len, M);
      chk(int'(dac_code) == (1 << (N - 1)), "R3", int'(dac_code), 1 << (N - 1));
      run_len = 0;
      k = N - 1;
    end else if (k >= 0) begin
      k--;
    end
    // R4/R5: partial word in every trial
    if (k >= 0) begin
      int exp_w = ((vin >> (k + 1)) << (k + 1)) | (1 << k);
      chk(int'(dac_code) == exp_w, "R4_R5", int'(dac_code), exp_w);
    end
    // R8: idle after a stop
    if (!start && dones_after_stop > 0 && !done) begin
      chk(!sample && dac_code == '0, "R8", int'(sample), 0);
    end
    // new input code at the first sampling clock
    if (sample && !prev_sample) begin
      vin = pick_code(conv_idx);
      conv_idx++;
    end
    prev_sample = sample;
    prev_done = done;
  endtask

  task automatic stop_mid_trial();
    int guard = 0;
    while (k != N / 2 && guard < 4 * PERIOD) begin step(); guard++; end
    start = 1'b0;
    dones_after_stop = 0;
    repeat (PERIOD + 20) step();
    chk(dones_after_stop == 1, "R8", dones_after_stop, 1);
    chk(!sample && !done, "R8", int'(sample), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    chk(!sample && !done && dac_code == '0 && result == '0, "R1",
        int'(sample) + int'(done) + int'(dac_code) + int'(result), 0);
    rst_n = 1'b1;
    start = 1'b1;
    repeat (40 * PERIOD) step();
    stop_mid_trial();
    have_done = 0;
    start = 1'b1;
    repeat (30 * PERIOD) step();
    stop_mid_trial();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule